// File: doc/BRIEF.md
# Four-Phase Dual-Rail / LEDR Bridge

This block sits between two delay-insensitive codes that are both sampled on one system clock. In the forward direction it receives words in the return-to-zero four-phase dual-rail code, in which every value is followed by an all-zero spacer, and re-issues each accepted value as a level-encoded dual-rail (LEDR) symbol. LEDR needs no spacer: each new value is marked by a change of phase. In the reverse direction it watches an LEDR bundle, detects each phase change as a new value and regenerates a four-phase word followed by a spacer, with an acknowledge wire setting the pace.

Each direction hands the accepted value to local synchronous logic as a one-cycle valid pulse with a data word. The four-phase input side answers its sender with an acknowledge level. Every LEDR bit uses a value rail and a parity rail, and its phase is their XOR. A four-phase bit of 1 is true rail high and false rail low; a bit of 0 is the reverse.

Top module: `dr_ledr_bridge`

## Requirements
- R1: After reset every output is low, which includes both LEDR output rails (phase 0, value 0), the acknowledge, the error flag and both valid pulses.
- R2: A four-phase word is accepted only when every bit pair is non-spacer, meaning exactly one rail high, with logic 1 = (true 1, false 0) and logic 0 = (true 0, false 1). On acceptance `fwd_valid` pulses for one cycle and `fwd_data` equals the true rails, two clock edges after the word is present. A word with only some pairs set is not accepted.
- R3: After acceptance `fp_in_ack` stays high. No second value is accepted until every pair has gone back to spacer (both rails 0), and only then does `fp_in_ack` drop. A different valid word that replaces the first without a spacer is ignored.
- R4: Any pair with both rails high raises `fwd_err`, and a word holding such a pair is not accepted. The flag clears once the illegal pair is gone.
- R5: Each accepted four-phase value appears on the LEDR output one cycle after `fwd_valid`, with the phase flipped. The first value after reset uses phase 1. The value rail carries the data bit and the parity rail carries the data bit XOR the phase.
- R6: Between accepted values the LEDR output rails hold steady, also while the four-phase input passes through its spacer.
- R7: The LEDR receiver accepts a symbol only when the phase of every bit differs from the phase it last accepted. It then pulses `rev_valid` for one cycle with `rev_data` equal to the value rails. A symbol in which only some bits have flipped is not accepted.
- R8: The LEDR receiver starts from phase 0 after reset, so a phase-0 symbol presented after reset is not accepted whatever its value.
- R9: Each value accepted from LEDR is driven on `fp_out_t`/`fp_out_f` as a four-phase word, held until `fp_out_ack` is seen high. The output then goes to spacer until `fp_out_ack` is seen low. No pair is ever driven with both rails high.
- R10: While the four-phase output handshake is still running, no LEDR symbol is accepted. A pending phase change is accepted once the handshake has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_in_t | input | W | Four-phase input, true rails |
| fp_in_f | input | W | Four-phase input, false rails |
| fp_in_ack | output | 1 | Acknowledge level returned to the four-phase sender |
| fwd_valid | output | 1 | One-cycle pulse when a four-phase value is accepted |
| fwd_data | output | W | Accepted four-phase value |
| fwd_err | output | 1 | Some input pair has both rails high |
| ledr_out_v | output | W | LEDR output, value rails |
| ledr_out_t | output | W | LEDR output, parity rails |
| ledr_in_v | input | W | LEDR input, value rails |
| ledr_in_t | input | W | LEDR input, parity rails |
| rev_valid | output | 1 | One-cycle pulse when an LEDR value is accepted |
| rev_data | output | W | Accepted LEDR value |
| fp_out_t | output | W | Regenerated four-phase output, true rails |
| fp_out_f | output | W | Regenerated four-phase output, false rails |
| fp_out_ack | input | 1 | Acknowledge from the four-phase receiver |

## Verification
A table drives the sequence 0, 0, 1, A, F through both directions. The two equal leading values show that a repeated value is still delivered as a new value, through the phase flip on the LEDR side and through the spacer on the four-phase side. The mixed words show that bits are encoded independently, and the alternating expected phases confirm the toggle order from phase 1. Directed patterns then try a partial four-phase word, a word with one pair at (1,1), a valid word replaced without a spacer, a partial LEDR phase flip, a phase-0 symbol right after reset, and an LEDR flip that arrives while the four-phase output is still waiting for its acknowledge. Each of these must be told apart from a real arrival.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

  // four-phase receive side: waiting for a full word, or waiting for spacer
  typedef enum logic {
    RX_WAIT = 1'b0,
    RX_HOLD = 1'b1
  } fprx_state_e;

  // four-phase transmit side
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_DATA   = 2'd1,
    TX_SPACER = 2'd2
  } fptx_state_e;

endpackage

// File: rtl/dlb_fp_rx.sv
module dlb_fp_rx #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rail_t,
  input  logic [W-1:0] rail_f,
  output logic         ack,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         err
);
  import dlb_pkg::*;

  logic [W-1:0] s_t, s_f;
  logic [W-1:0] pair_live, pair_bad;
  logic         word_live, word_idle;
  fprx_state_e  state;

  for (genvar i = 0; i < W; i++) begin : g_pair
    assign pair_live[i] = s_t[i] ^ s_f[i];
    assign pair_bad[i]  = s_t[i] & s_f[i];
  end

  assign word_live = &pair_live;
  assign word_idle = ~|(s_t | s_f);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_t   <= '0;
      s_f   <= '0;
      state <= RX_WAIT;
      ack   <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
      err   <= 1'b0;
    end else begin
      s_t   <= rail_t;
      s_f   <= rail_f;
      err   <= |pair_bad;
      valid <= 1'b0;
      case (state)
        RX_WAIT: if (word_live) begin
          valid <= 1'b1;
          data  <= s_t;
          ack   <= 1'b1;
          state <= RX_HOLD;
        end
        RX_HOLD: if (word_idle) begin
          ack   <= 1'b0;
          state <= RX_WAIT;
        end
        default: state <= RX_WAIT;
      endcase
    end
  end

  // R2: an arrival is always accompanied by the acknowledge
  a_r2_valid_with_ack: assert property (@(posedge clk) disable iff (rst)
    valid |-> ack);
  // R3: one pulse per word
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R3: acknowledge only falls after a full spacer has been seen
  a_r3_ack_until_spacer: assert property (@(posedge clk) disable iff (rst)
    (ack && !word_idle) |=> ack);
  // R4: an illegal pair never produces an arrival
  a_r4_err_no_valid: assert property (@(posedge clk) disable iff (rst)
    err |-> !valid);

endmodule

// File: rtl/dlb_ledr_tx.sv
module dlb_ledr_tx #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic [W-1:0] rail_v,
  output logic [W-1:0] rail_t
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      rail_v <= '0;
      rail_t <= '0;
    end else if (load) begin
      phase  <= ~phase;
      rail_v <= value;
      rail_t <= value ^ {W{~phase}};
    end
  end

  // R5: every load changes the phase seen on the wires
  a_r5_phase_flips: assert property (@(posedge clk) disable iff (rst)
    load |=> ((rail_v ^ rail_t) != $past(rail_v ^ rail_t)));
  // R5: all bits of a symbol share one phase
  a_r5_uniform_phase: assert property (@(posedge clk) disable iff (rst)
    (&(rail_v ^ rail_t)) || !(|(rail_v ^ rail_t)));
  // R6: rails hold between loads
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(rail_v) && $stable(rail_t)));

endmodule

// File: rtl/dlb_ledr_rx.sv
module dlb_ledr_rx #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rail_v,
  input  logic [W-1:0] rail_t,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  logic [W-1:0] s_v, s_t, bit_phase;
  logic         phase;
  logic         fresh;

  for (genvar i = 0; i < W; i++) begin : g_phase
    assign bit_phase[i] = s_v[i] ^ s_t[i];
  end

  assign fresh = (bit_phase == {W{~phase}});

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v   <= '0;
      s_t   <= '0;
      phase <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      s_v   <= rail_v;
      s_t   <= rail_t;
      valid <= 1'b0;
      if (fresh && ready) begin
        phase <= ~phase;
        valid <= 1'b1;
        data  <= s_v;
      end
    end
  end

  // R7: one pulse per phase change
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R10: acceptance only while the downstream handshake is free
  a_r10_wait_ready: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(ready));

endmodule

// File: rtl/dlb_fp_tx.sv
module dlb_fp_tx #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  input  logic         ack,
  output logic [W-1:0] rail_t,
  output logic [W-1:0] rail_f,
  output logic         ready
);
  import dlb_pkg::*;

  fptx_state_e state;
  logic        ack_s;

  assign ready = (state == TX_IDLE) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      ack_s  <= 1'b0;
      rail_t <= '0;
      rail_f <= '0;
    end else begin
      ack_s <= ack;
      case (state)
        TX_IDLE: if (load) begin
          rail_t <= value;
          rail_f <= ~value;
          state  <= TX_DATA;
        end
        TX_DATA: if (ack_s) begin
          rail_t <= '0;
          rail_f <= '0;
          state  <= TX_SPACER;
        end
        TX_SPACER: if (!ack_s) state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R9: never both rails of a pair
  a_r9_no_illegal: assert property (@(posedge clk) disable iff (rst)
    !(|(rail_t & rail_f)));
  // R9: data word held until acknowledge is seen
  a_r9_data_held: assert property (@(posedge clk) disable iff (rst)
    (state == TX_DATA && !ack_s) |=> ($stable(rail_t) && $stable(rail_f)));
  // R10: no readiness while a word is on the rails
  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    (|(rail_t | rail_f)) |-> !ready);

endmodule

// File: rtl/dr_ledr_bridge.sv
module dr_ledr_bridge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fp_in_t,
  input  logic [W-1:0] fp_in_f,
  output logic         fp_in_ack,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data,
  output logic         fwd_err,
  output logic [W-1:0] ledr_out_v,
  output logic [W-1:0] ledr_out_t,
  input  logic [W-1:0] ledr_in_v,
  input  logic [W-1:0] ledr_in_t,
  output logic         rev_valid,
  output logic [W-1:0] rev_data,
  output logic [W-1:0] fp_out_t,
  output logic [W-1:0] fp_out_f,
  input  logic         fp_out_ack
);
  logic tx_ready;

  dlb_fp_rx #(.W(W)) u_fp_rx (
    .clk(clk), .rst(rst),
    .rail_t(fp_in_t), .rail_f(fp_in_f),
    .ack(fp_in_ack), .valid(fwd_valid), .data(fwd_data), .err(fwd_err)
  );

  dlb_ledr_tx #(.W(W)) u_ledr_tx (
    .clk(clk), .rst(rst),
    .load(fwd_valid), .value(fwd_data),
    .rail_v(ledr_out_v), .rail_t(ledr_out_t)
  );

  dlb_ledr_rx #(.W(W)) u_ledr_rx (
    .clk(clk), .rst(rst),
    .rail_v(ledr_in_v), .rail_t(ledr_in_t),
    .ready(tx_ready), .valid(rev_valid), .data(rev_data)
  );

  dlb_fp_tx #(.W(W)) u_fp_tx (
    .clk(clk), .rst(rst),
    .load(rev_valid), .value(rev_data), .ack(fp_out_ack),
    .rail_t(fp_out_t), .rail_f(fp_out_f), .ready(tx_ready)
  );

  // R1: all outputs quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!fwd_valid && !rev_valid && !fp_in_ack &&
                    ledr_out_v == '0 && ledr_out_t == '0));

endmodule

// File: tb/tb_dr_ledr_bridge.sv
module tb_dr_ledr_bridge;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] fp_in_t = '0, fp_in_f = '0;
  logic [W-1:0] ledr_in_v = '0, ledr_in_t = '0;
  logic fp_out_ack = 1'b0;
  logic fp_in_ack, fwd_valid, fwd_err, rev_valid;
  logic [W-1:0] fwd_data, ledr_out_v, ledr_out_t, rev_data, fp_out_t, fp_out_f;

  always #2.5 clk = ~clk;

  dr_ledr_bridge #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .fp_in_t(fp_in_t), .fp_in_f(fp_in_f), .fp_in_ack(fp_in_ack),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_err(fwd_err),
    .ledr_out_v(ledr_out_v), .ledr_out_t(ledr_out_t),
    .ledr_in_v(ledr_in_v), .ledr_in_t(ledr_in_t),
    .rev_valid(rev_valid), .rev_data(rev_data),
    .fp_out_t(fp_out_t), .fp_out_f(fp_out_f), .fp_out_ack(fp_out_ack)
  );

  // each entry: {value, expected forward LEDR phase after sending it}
  localparam logic [4:0] VEC [5] = '{5'b0000_1, 5'b0000_0, 5'b0001_1,
                                     5'b1010_0, 5'b1111_1};

  int total = 0, bad = 0, cycles = 0;
  int fwd_cnt = 0, rev_cnt = 0;
  logic [W-1:0] fwd_last = '0, rev_last = '0;
  logic rx_ph = 1'b0;

  always @(negedge clk) begin
    if (fwd_valid) begin fwd_cnt++; fwd_last = fwd_data; end
    if (rev_valid) begin rev_cnt++; rev_last = rev_data; end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fwd_send(input logic [W-1:0] val, input logic ph);
    int c0 = fwd_cnt;
    fp_in_t = val; fp_in_f = ~val;
    for (int i = 0; i < 10 && !fp_in_ack; i++) tick();
    chk(fp_in_ack == 1'b1, "R3 ack raised", fp_in_ack, 1);
    tick();
    chk(fwd_cnt == c0 + 1, "R2 one pulse", fwd_cnt - c0, 1);
    chk(fwd_last == val, "R2 data", fwd_last, val);
    chk(ledr_out_v == val, "R5 value rails", ledr_out_v, val);
    chk(ledr_out_t == (val ^ {W{ph}}), "R5 parity rails", ledr_out_t, val ^ {W{ph}});
    fp_in_t = '0; fp_in_f = '0;
    for (int i = 0; i < 10 && fp_in_ack; i++) tick();
    chk(fp_in_ack == 1'b0, "R3 ack drops after spacer", fp_in_ack, 0);
    chk(ledr_out_v == val && ledr_out_t == (val ^ {W{ph}}), "R6 LEDR held",
        ledr_out_t, val ^ {W{ph}});
  endtask

  task automatic rev_send(input logic [W-1:0] val);
    int c0 = rev_cnt;
    rx_ph = ~rx_ph;
    ledr_in_v = val; ledr_in_t = val ^ {W{rx_ph}};
    for (int i = 0; i < 10 && rev_cnt == c0; i++) tick();
    chk(rev_cnt == c0 + 1, "R7 one pulse", rev_cnt - c0, 1);
    chk(rev_last == val, "R7 data", rev_last, val);
    tick();
    chk(fp_out_t == val && fp_out_f == ~val, "R9 data word", fp_out_t, val);
    fp_out_ack = 1'b1;
    for (int i = 0; i < 10 && (fp_out_t | fp_out_f) != '0; i++) tick();
    chk((fp_out_t | fp_out_f) == '0, "R9 spacer after ack", fp_out_t | fp_out_f, 0);
    fp_out_ack = 1'b0;
    tick(); tick(); tick();
  endtask

  initial begin
    int c0;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(!fwd_valid && !fp_in_ack && !fwd_err && !rev_valid, "R1 flags", fp_in_ack, 0);
    chk(ledr_out_v == '0 && ledr_out_t == '0, "R1 LEDR rails", ledr_out_t, 0);
    chk((fp_out_t | fp_out_f) == '0, "R1 four-phase out", fp_out_t | fp_out_f, 0);

    // R8 phase-0 symbol after reset is not new
    ledr_in_v = 4'h5; ledr_in_t = 4'h5;
    repeat (5) tick();
    chk(rev_cnt == 0, "R8 phase-0 ignored", rev_cnt, 0);
    chk((fp_out_t | fp_out_f) == '0, "R8 no output word", fp_out_t | fp_out_f, 0);

    // table walk, both directions
    for (int k = 0; k < 5; k++) begin
      fwd_send(VEC[k][4:1], VEC[k][0]);
      rev_send(VEC[k][4:1]);
    end

    // R2 partial four-phase word
    c0 = fwd_cnt;
    fp_in_t = 4'b0001; fp_in_f = 4'b0000;
    repeat (5) tick();
    chk(fwd_cnt == c0 && !fp_in_ack, "R2 partial ignored", fwd_cnt - c0, 0);
    fp_in_t = '0; tick(); tick();

    // R4 illegal pair
    fp_in_t = 4'b1111; fp_in_f = 4'b0001;
    repeat (4) tick();
    chk(fwd_err == 1'b1, "R4 err raised", fwd_err, 1);
    chk(fwd_cnt == c0, "R4 no accept", fwd_cnt - c0, 0);
    fp_in_t = '0; fp_in_f = '0;
    repeat (3) tick();
    chk(fwd_err == 1'b0, "R4 err clears", fwd_err, 0);

    // R3 new valid word without spacer is ignored (phase now 1 -> 0)
    fp_in_t = 4'h3; fp_in_f = 4'hC;
    for (int i = 0; i < 10 && !fp_in_ack; i++) tick();
    tick();
    chk(fwd_cnt == c0 + 1 && fwd_last == 4'h3, "R3 first word", fwd_last, 3);
    fp_in_t = 4'hC; fp_in_f = 4'h3;
    repeat (5) tick();
    chk(fwd_cnt == c0 + 1, "R3 no re-accept", fwd_cnt - c0, 1);
    chk(ledr_out_v == 4'h3 && ledr_out_t == 4'h3, "R3 LEDR unchanged", ledr_out_v, 3);
    fp_in_t = '0; fp_in_f = '0;
    for (int i = 0; i < 10 && fp_in_ack; i++) tick();
    chk(!fp_in_ack, "R3 ack drops", fp_in_ack, 0);

    // R7 partial phase flip
    c0 = rev_cnt;
    ledr_in_t = ledr_in_t ^ 4'b0001;
    repeat (5) tick();
    chk(rev_cnt == c0, "R7 partial flip ignored", rev_cnt - c0, 0);

    // R10 flip while output handshake busy
    rx_ph = ~rx_ph;
    ledr_in_v = 4'h6; ledr_in_t = 4'h6 ^ {W{rx_ph}};
    for (int i = 0; i < 10 && rev_cnt == c0; i++) tick();
    tick();
    chk(rev_cnt == c0 + 1 && fp_out_t == 4'h6, "R10 first accepted", fp_out_t, 6);
    rx_ph = ~rx_ph;
    ledr_in_v = 4'h9; ledr_in_t = 4'h9 ^ {W{rx_ph}};
    repeat (6) tick();
    chk(rev_cnt == c0 + 1, "R10 held off", rev_cnt - c0, 1);
    chk(fp_out_t == 4'h6 && fp_out_f == 4'h9, "R9 word held without ack", fp_out_t, 6);
    fp_out_ack = 1'b1;
    for (int i = 0; i < 10 && (fp_out_t | fp_out_f) != '0; i++) tick();
    fp_out_ack = 1'b0;
    for (int i = 0; i < 10 && rev_cnt == c0 + 1; i++) tick();
    chk(rev_cnt == c0 + 2 && rev_last == 4'h9, "R10 pending accepted", rev_last, 9);
    tick();
    chk(fp_out_t == 4'h9 && fp_out_f == 4'h6, "R9 second word", fp_out_t, 9);
    fp_out_ack = 1'b1;
    repeat (4) tick();
    fp_out_ack = 1'b0;
    repeat (4) tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule